// File: doc/BRIEF.md
# Reconfigurable Sinc3 Decimator

This block turns the 1-bit output stream of a second-order sigma-delta modulator into 14-bit words. It is a third-order cascaded integrator-comb filter. Three integrators run at the modulator sample rate, and three comb stages run once every D samples. The decimation factor D is a power of two from 32 to 2048. A 4-bit rate code selects it while the block is running.

All stages share one 34-bit accumulator width, which is sized for the largest factor. An internal controller does three things: it produces the comb update tick, it drops the results that are corrupted after a rate change, and it moves a 14-bit output window so that the word always holds the top valid bits for the selected factor. A downstream user holds `rate_code` steady, samples `sd_bit` on every clock, and takes `dec_word` whenever `dec_valid` pulses.

Top module: `sinc3_decimator`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `dec_valid` is 0 and `dec_word` is 0.
- R2: A rate code c from 0 to 6 selects D = 2^(c+5), so code 0 gives 32 and code 6 gives 2048. In steady state, `dec_valid` pulses exactly every D clock cycles. The integrators advance every cycle, and the comb delay registers change only on the decimated tick.
- R3: Any rate code from 7 to 15 behaves as D = 32.
- R4: `dec_valid` is high for a single cycle at a time. `dec_word` holds its value between pulses.
- R5: A change of `rate_code` restarts the decimation counter and clears every comb delay register. It also discards the next three comb results. The first pulse then comes 4·D cycles after the clock edge that registers the new code.
- R6: A `sd_bit` of 1 counts as +1 and a 0 counts as −1. The gain is D^3. `dec_word` is bits [3·log2(D) : 3·log2(D)−13] of the third comb output, read as two's complement. With D a multiple of 4, steady input densities of 3/4, 1/2 and 1/4 ones give 4096, 0 and −4096 respectively.
- R7: The accumulators are 34 bits wide and wrap modulo 2^34. A steady all-zeros input gives 14'h2000 (−8192). A steady all-ones input wraps to the same 14'h2000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_bit | input | 1 | Modulator bit stream, one bit per clock |
| rate_code | input | 4 | Decimation factor select |
| dec_word | output | 14 | Decimated output word, two's complement |
| dec_valid | output | 1 | One-cycle strobe marking a new word |

## Verification
Assertions check the following on every cycle:
- the counter stays inside the window for the selected factor;
- a code change leaves the counter at zero and the three-result skip armed;
- the comb delays stay put between ticks and are empty after a clear;
- each integrator-input step is exactly +1 or −1;
- the output strobe is one cycle wide and the word holds between strobes.

Only the bench scenarios can show the rest: the exact strobe spacing for each factor, the fallback of out-of-range codes, the 4·D delay to the first word after a change, and the numeric word for each input density, including the wrap at full scale.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
    localparam int ORDER        = 3;
    localparam int DIFF_DELAY   = 1;
    localparam int IN_W         = 1;
    localparam int MIN_LOG2     = 5;
    localparam int MAX_LOG2     = 11;
    localparam int NUM_FACTORS  = MAX_LOG2 - MIN_LOG2 + 1;
    localparam int CODE_W       = 4;
    localparam int OUT_W        = 14;
    localparam int SKIP_RESULTS = 3;
    localparam int ACC_W        = ORDER * (MAX_LOG2 + $clog2(DIFF_DELAY)) + IN_W;
    localparam int LOG2_W       = $clog2(MAX_LOG2 + 1);
    localparam int CNT_W        = MAX_LOG2 + 1;
    localparam int SKIP_W       = $clog2(SKIP_RESULTS + 1);
    localparam int SHIFT_W      = $clog2(ACC_W);

    // Map the rate code to log2 of the decimation factor; out-of-range codes use the smallest factor.
    function automatic logic [LOG2_W-1:0] code_to_log2(input logic [CODE_W-1:0] code);
        if (int'(code) < NUM_FACTORS) begin
            return LOG2_W'(int'(code) + MIN_LOG2);
        end
        return LOG2_W'(MIN_LOG2);
    endfunction
endpackage

// File: rtl/sinc3_ctrl.sv
module sinc3_ctrl
    import sinc3_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_i,
    output logic              integ_en_o,
    output logic              comb_en_o,
    output logic              clear_o,
    output logic              emit_o,
    output logic [LOG2_W-1:0] log2_o
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [CNT_W-1:0]  cnt;
        logic [SKIP_W-1:0] skip;
        logic              run;
    } ctrl_t;

    ctrl_t             st_q, st_d;
    logic [LOG2_W-1:0] log2_cur;
    logic [CNT_W-1:0]  last_cnt;
    logic              change;
    logic              tick;

    always_comb begin
        log2_cur = code_to_log2(st_q.code);
        last_cnt = (CNT_W'(1) << log2_cur) - CNT_W'(1);
        change   = (code_i != st_q.code);
        tick     = st_q.run && (st_q.cnt == last_cnt) && !change;

        st_d      = st_q;
        st_d.run  = 1'b1;
        st_d.code = code_i;
        if (change) begin
            st_d.cnt  = '0;
            st_d.skip = SKIP_W'(SKIP_RESULTS);
        end else if (st_q.run) begin
            if (st_q.cnt == last_cnt) begin
                st_d.cnt = '0;
                if (st_q.skip != '0) begin
                    st_d.skip = st_q.skip - SKIP_W'(1);
                end
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign integ_en_o = st_q.run;
    assign comb_en_o  = tick;
    assign clear_o    = change;
    assign emit_o     = tick && (st_q.skip == '0);
    assign log2_o     = log2_cur;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= last_cnt); // R2

    AST_CHANGE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        change |=> (st_q.cnt == '0) && (st_q.skip == SKIP_W'(SKIP_RESULTS))); // R5
endmodule

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
    parameter int W      = sinc3_pkg::ACC_W,
    parameter int STAGES = sinc3_pkg::ORDER
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         bit_i,
    output logic [W-1:0] acc_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] acc;
    } integ_t;

    integ_t                   st_q, st_d;
    logic [W-1:0]             step;
    logic [STAGES-1:0][W-1:0] acc_nxt;

    assign step = bit_i ? W'(1) : {W{1'b1}};

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign acc_nxt[g] = st_q.acc[g] + step;
        end else begin : g_chain
            assign acc_nxt[g] = st_q.acc[g] + st_q.acc[g-1];
        end
    end

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            st_d.acc = acc_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o = st_q.acc[STAGES-1];

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> ((st_q.acc[0] - $past(st_q.acc[0])) == W'(1)) ||
                 ((st_q.acc[0] - $past(st_q.acc[0])) == {W{1'b1}})); // R6
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
    parameter int W      = sinc3_pkg::ACC_W,
    parameter int STAGES = sinc3_pkg::ORDER
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         clr_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] res_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] dly;
    } comb_t;

    comb_t                    st_q, st_d;
    logic [STAGES-1:0][W-1:0] diff;
    logic [STAGES-1:0][W-1:0] stage_in;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign stage_in[g] = din_i;
        end else begin : g_chain
            assign stage_in[g] = diff[g-1];
        end
        assign diff[g] = stage_in[g] - st_q.dly[g];
    end

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.dly = '0;
        end else if (en_i) begin
            st_d.dly = stage_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o = diff[STAGES-1];

    AST_COMB_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.dly == '0)); // R5

    AST_COMB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> $stable(st_q.dly)); // R2
endmodule

// File: rtl/sinc3_decimator.sv
module sinc3_decimator
    import sinc3_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sd_bit,
    input  logic [CODE_W-1:0] rate_code,
    output logic [OUT_W-1:0]  dec_word,
    output logic              dec_valid
);
    typedef struct packed {
        logic [OUT_W-1:0] word;
        logic             valid;
    } out_t;

    out_t               out_q, out_d;
    logic               integ_en;
    logic               comb_en;
    logic               clear;
    logic               emit;
    logic [LOG2_W-1:0]  log2_sel;
    logic [ACC_W-1:0]   integ_out;
    logic [ACC_W-1:0]   comb_out;
    logic [SHIFT_W-1:0] win_shift;

    sinc3_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_i     (rate_code),
        .integ_en_o (integ_en),
        .comb_en_o  (comb_en),
        .clear_o    (clear),
        .emit_o     (emit),
        .log2_o     (log2_sel)
    );

    sinc3_integ #(.W(ACC_W), .STAGES(ORDER)) u_integ (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (integ_en),
        .bit_i (sd_bit),
        .acc_o (integ_out)
    );

    sinc3_comb #(.W(ACC_W), .STAGES(ORDER)) u_comb (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (comb_en),
        .clr_i (clear),
        .din_i (integ_out),
        .res_o (comb_out)
    );

    always_comb begin
        win_shift = SHIFT_W'(ORDER * int'(log2_sel) - (OUT_W - 1));
        out_d       = out_q;
        out_d.valid = emit;
        if (emit) begin
            out_d.word = OUT_W'(comb_out >> win_shift);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign dec_word  = out_q.word;
    assign dec_valid = out_q.valid;

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid); // R4

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !emit |=> $stable(dec_word)); // R4
endmodule

// File: tb/sinc3_decimator_bench.sv
module sinc3_decimator_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sd_bit = 1'b0;
    logic [3:0]  rate_code = 4'd0;
    logic [13:0] dec_word;
    logic        dec_valid;

    int          n_checks = 0;
    int          n_fail = 0;
    int          pat_sel = 0;
    logic [1:0]  ph = 2'd0;

    sinc3_decimator u_sinc3_decimator (
        .clk       (clk),
        .rst_n     (rst_n),
        .sd_bit    (sd_bit),
        .rate_code (rate_code),
        .dec_word  (dec_word),
        .dec_valid (dec_valid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Pattern source: 0 alternating, 1 three ones in four, 2 one in four, 3 all zeros, 4 all ones.
    initial begin
        forever begin
            @(negedge clk);
            ph <= ph + 2'd1;
            case (pat_sel)
                0:       sd_bit <= ph[0];
                1:       sd_bit <= (ph != 2'd0);
                2:       sd_bit <= (ph == 2'd0);
                3:       sd_bit <= 1'b0;
                default: sd_bit <= 1'b1;
            endcase
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_valid(output int cyc);
        cyc = 0;
        do begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end while (!dec_valid && cyc < 20000);
    endtask

    // Switch rate and pattern, then check latency, value, strobe width and spacing.
    task automatic run_case(input logic [3:0] code, input int pat, input int dfac,
                            input logic [13:0] exp_word, input string rate_req,
                            input string val_req);
        int c;
        @(negedge clk);
        rate_code = code;
        pat_sel   = pat;
        wait_valid(c);
        check(c == 4 * dfac + 1, "R5", c, 4 * dfac + 1);
        check(dec_word == exp_word, val_req, int'($signed(dec_word)), int'($signed(exp_word)));
        @(posedge clk);
        @(negedge clk);
        check(!dec_valid, "R4", int'(dec_valid), 0);
        check(dec_word == exp_word, "R4", int'($signed(dec_word)), int'($signed(exp_word)));
        wait_valid(c);
        check(c == dfac - 1, rate_req, c + 1, dfac);
        check(dec_word == exp_word, val_req, int'($signed(dec_word)), int'($signed(exp_word)));
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(dec_valid == 1'b0, "R1", int'(dec_valid), 0);
        check(dec_word == 14'd0, "R1", int'(dec_word), 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(dec_valid == 1'b0, "R1", int'(dec_valid), 0);
        check(dec_word == 14'd0, "R1", int'(dec_word), 0);
    endtask

    task automatic t_three_quarter_d64;
        run_case(4'd1, 1, 64, 14'h1000, "R2", "R6");
    endtask

    task automatic t_alternating_d32;
        run_case(4'd0, 0, 32, 14'h0000, "R2", "R6");
    endtask

    task automatic t_quarter_d256;
        run_case(4'd3, 2, 256, 14'h3000, "R2", "R6");
    endtask

    task automatic t_full_ones_wrap_d128;
        run_case(4'd2, 4, 128, 14'h2000, "R2", "R7");
    endtask

    task automatic t_zeros_d2048;
        run_case(4'd6, 3, 2048, 14'h2000, "R2", "R7");
    endtask

    task automatic t_invalid_codes;
        run_case(4'd9, 1, 32, 14'h1000, "R3", "R6");
        run_case(4'd15, 0, 32, 14'h0000, "R3", "R6");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_three_quarter_d64();
        t_alternating_d32();
        t_quarter_d256();
        t_full_ones_wrap_d128();
        t_zeros_d2048();
        t_invalid_codes();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule